// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Read Cache

This block sits between a processor load port and a slow backing memory. The processor presents one byte address at a time. The cache answers with the addressed byte and a flag that says whether the byte was already held. The cache has two sets of two lines each, and every line holds a two-byte block. A lookup selects one set from the address and compares the request tag against both lines of that set in the same cycle.

On a miss, the cache asks the backing memory for the whole two-byte block that contains the address. While that fetch is outstanding it holds off further requests. When the block arrives, the cache writes it into a chosen line of the set and returns the requested byte. The line to replace is an empty line if the set has one. Otherwise it is the line of that set used least recently, tracked by one bit per set.

Two running counters of hits and misses are exposed, so a test sequence can be followed from the outside.

Top module: `rd_cache2w`

## Requirements
- R1: A synchronous active-high reset empties every line, clears both counters, drives req_ready high and holds rsp_valid and mem_req_valid low; the first load after reset is a miss.
- R2: The 5-bit byte address is split as tag = addr[4:2], set = addr[1], byte offset = addr[0]; the block address sent to memory is addr[4:1].
- R3: On a miss, mem_req_valid rises on the clock edge that accepts the load. mem_req_valid and mem_req_addr then stay unchanged until the edge where mem_rsp_valid is high, and req_ready stays low for that whole time.
- R4: On a fill, rsp_valid goes high for one cycle right after the edge where mem_rsp_valid is seen, with rsp_hit = 0. rsp_data is mem_rsp_data[7:0] for offset 0 and mem_rsp_data[15:8] for offset 1.
- R5: A hit raises rsp_valid for one cycle after the accepting edge, with rsp_hit = 1, the stored byte, and no memory request.
- R6: After a miss fills a block, a load of the other byte of the same block hits.
- R7: A set that still has an empty line fills that line, so two blocks with different tags in one set are both kept.
- R8: When both lines of the set are full, a miss replaces the line used least recently, where both hits and fills count as uses.
- R9: hit_count and miss_count each grow by exactly one for every accepted load of their kind, and by nothing otherwise.
- R10: Filling a line in one set leaves the contents of the other set unchanged.
- R11: A req_valid presented while req_ready is low is not accepted: it causes no response and no counter change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_addr | input | 5 | Byte address of the load |
| req_ready | output | 1 | Cache can accept a load this cycle |
| rsp_valid | output | 1 | Response byte valid (one cycle) |
| rsp_data | output | 8 | Returned byte |
| rsp_hit | output | 1 | 1 if the load hit, 0 if it was filled |
| mem_req_valid | output | 1 | Block fetch request to backing memory |
| mem_req_addr | output | 4 | Block address of the fetch |
| mem_rsp_valid | input | 1 | Backing memory returns the block |
| mem_rsp_data | input | 16 | Returned block, byte 0 in the low bits |
| hit_count | output | 16 | Number of hits since reset |
| miss_count | output | 16 | Number of misses since reset |

## Verification
Most faults in the stored state show up on the port within one load. A stale valid bit or a wrong tag makes a load that should hit instead start a memory fetch, or the reverse. A fill written into the wrong line shows up as a miss on a block that should still be held. An LRU bit that points the wrong way stays hidden until a third distinct block enters the same set; the load after that replacement then hits or misses the wrong block. The directed sequences therefore re-read every block they expect to keep, right after each replacement.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } rdc_state_e;
endpackage

// File: rtl/rdc_tag_store.sv
module rdc_tag_store #(
  parameter int SETS  = 2,
  parameter int WAYS  = 2,
  parameter int TAG_W = 3,
  parameter int SET_W = 1,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  valid_vec,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [WAYS-1:0]  valid_q [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign valid_vec[w] = valid_q[lk_set][w];
    assign hit_vec[w]   = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  // R7: never two live copies of one tag in a set
  p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/rdc_data_store.sv
module rdc_data_store #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_line;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_line <= mem_q[rd_idx];
  end
endmodule

// File: rtl/rdc_lru.sv
module rdc_lru #(
  parameter int SETS  = 2,
  parameter int SET_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [SET_W-1:0] upd_set,
  input  logic             used_way,
  input  logic [SET_W-1:0] rd_set,
  output logic             evict_way
);
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst) lru_q <= '0;
    else if (upd_en) lru_q[upd_set] <= ~used_way;
  end

  assign evict_way = lru_q[rd_set];

  // R8: after a use, the set points away from the way just used
  p_points_away_r8: assert property (@(posedge clk) disable iff (rst)
    upd_en && (rd_set == upd_set) |=> (evict_way != $past(used_way)) || ($past(rd_set) != rd_set));
endmodule

// File: rtl/rd_cache2w.sv
module rd_cache2w #(
  parameter int ADDR_W = 5,
  parameter int SET_W  = 1,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  output logic                        req_ready,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_data,
  output logic                        rsp_hit,
  output logic                        mem_req_valid,
  output logic [ADDR_W-OFF_W-1:0]     mem_req_addr,
  input  logic                        mem_rsp_valid,
  input  logic [DATA_W*(2**OFF_W)-1:0] mem_rsp_data,
  output logic [CNT_W-1:0]            hit_count,
  output logic [CNT_W-1:0]            miss_count
);
  import rdc_pkg::*;

  localparam int WAYS      = 2;
  localparam int WAY_W     = 1;
  localparam int SETS      = 2 ** SET_W;
  localparam int TAG_W     = ADDR_W - SET_W - OFF_W;
  localparam int BLK_BYTES = 2 ** OFF_W;
  localparam int LINE_W    = DATA_W * BLK_BYTES;
  localparam int IDX_W     = SET_W + WAY_W;
  localparam int BLK_W     = ADDR_W - OFF_W;

  rdc_state_e state_q;

  logic [TAG_W-1:0] req_tag;
  logic [SET_W-1:0] req_set;
  logic [OFF_W-1:0] req_off;
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign req_set = req_addr[OFF_W +: SET_W];
  assign req_off = req_addr[OFF_W-1:0];

  logic [TAG_W-1:0] pend_tag_q;
  logic [SET_W-1:0] pend_set_q;
  logic [OFF_W-1:0] pend_off_q;
  logic [WAY_W-1:0] victim_q;
  logic [OFF_W-1:0] off_q;
  logic             from_fill_q;
  logic [DATA_W-1:0] fill_byte_q;
  logic             rsp_valid_q, rsp_hit_q, mreq_q;
  logic [BLK_W-1:0] mreq_addr_q;
  logic [CNT_W-1:0] hit_cnt_q, miss_cnt_q;

  logic [WAYS-1:0]   hit_vec, valid_vec;
  logic              hit_any, hit_way, lru_evict, accept, fill_done;
  logic [WAY_W-1:0]  victim;
  logic [LINE_W-1:0] rd_line;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign fill_done = (state_q == ST_FILL) && mem_rsp_valid;
  assign hit_any   = |hit_vec;
  assign hit_way   = hit_vec[1];

  always_comb begin
    if (!valid_vec[0])      victim = 1'b0;
    else if (!valid_vec[1]) victim = 1'b1;
    else                    victim = lru_evict;
  end

  rdc_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst(rst),
    .lk_set(req_set), .lk_tag(req_tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec),
    .wr_en(fill_done), .wr_set(pend_set_q), .wr_way(victim_q), .wr_tag(pend_tag_q)
  );

  rdc_data_store #(
    .DEPTH(SETS * WAYS), .IDX_W(IDX_W), .LINE_W(LINE_W)
  ) u_data (
    .clk(clk),
    .wr_en(fill_done), .wr_idx({pend_set_q, victim_q}), .wr_line(mem_rsp_data),
    .rd_en(accept && hit_any), .rd_idx({req_set, hit_way}), .rd_line(rd_line)
  );

  rdc_lru #(
    .SETS(SETS), .SET_W(SET_W)
  ) u_lru (
    .clk(clk), .rst(rst),
    .upd_en((accept && hit_any) || fill_done),
    .upd_set(fill_done ? pend_set_q : req_set),
    .used_way(fill_done ? victim_q : hit_way),
    .rd_set(req_set),
    .evict_way(lru_evict)
  );

  logic [DATA_W-1:0] line_bytes [BLK_BYTES];
  logic [DATA_W-1:0] fill_bytes [BLK_BYTES];
  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_bytes
    assign line_bytes[b] = rd_line[b*DATA_W +: DATA_W];
    assign fill_bytes[b] = mem_rsp_data[b*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      mreq_q      <= 1'b0;
      mreq_addr_q <= '0;
      hit_cnt_q   <= '0;
      miss_cnt_q  <= '0;
      from_fill_q <= 1'b0;
      fill_byte_q <= '0;
      off_q       <= '0;
      pend_tag_q  <= '0;
      pend_set_q  <= '0;
      pend_off_q  <= '0;
      victim_q    <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        if (hit_any) begin
          rsp_valid_q <= 1'b1;
          rsp_hit_q   <= 1'b1;
          from_fill_q <= 1'b0;
          off_q       <= req_off;
          hit_cnt_q   <= hit_cnt_q + 1'b1;
        end else begin
          state_q     <= ST_FILL;
          mreq_q      <= 1'b1;
          mreq_addr_q <= req_addr[ADDR_W-1:OFF_W];
          pend_tag_q  <= req_tag;
          pend_set_q  <= req_set;
          pend_off_q  <= req_off;
          victim_q    <= victim;
          miss_cnt_q  <= miss_cnt_q + 1'b1;
        end
      end else if (fill_done) begin
        state_q     <= ST_IDLE;
        mreq_q      <= 1'b0;
        rsp_valid_q <= 1'b1;
        rsp_hit_q   <= 1'b0;
        from_fill_q <= 1'b1;
        fill_byte_q <= fill_bytes[pend_off_q];
      end
    end
  end

  assign rsp_valid     = rsp_valid_q;
  assign rsp_hit       = rsp_hit_q;
  assign rsp_data      = from_fill_q ? fill_byte_q : line_bytes[off_q];
  assign mem_req_valid = mreq_q;
  assign mem_req_addr  = mreq_addr_q;
  assign hit_count     = hit_cnt_q;
  assign miss_count    = miss_cnt_q;

  // R3: an outstanding fetch holds its request and address
  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_rsp_valid |=> mem_req_valid && $stable(mem_req_addr));
  // R11: nothing is accepted while a fetch is pending
  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
  // R5: a response follows an acceptance or a returned block
  p_rsp_cause_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready) || $past(mem_rsp_valid && mem_req_valid));
  // R5: a hit response never comes with a fetch in flight
  p_hit_no_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hit |-> !mem_req_valid);
  // R9: counters move only on an accepted load
  p_count_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> $stable(hit_count) && $stable(miss_count));
endmodule

// File: tb/tb_rd_cache2w.sv
module tb_rd_cache2w;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [4:0]  req_addr = '0;
  logic        req_ready, rsp_valid, rsp_hit, mem_req_valid;
  logic [7:0]  rsp_data;
  logic [3:0]  mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic [15:0] hit_count, miss_count;

  int errors = 0;
  int checks = 0;
  int exp_hits = 0;
  int exp_miss = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rd_cache2w dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [7:0] mem_byte(input logic [4:0] a);
    return 8'((int'(a) * 37 + 11) & 8'hFF);
  endfunction

  function automatic logic [15:0] mem_block(input logic [3:0] b);
    return {mem_byte({b, 1'b1}), mem_byte({b, 1'b0})};
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic chk_counts(input string rq);
    chk(hit_count == 16'(exp_hits), {rq, " hit_count"}, int'(hit_count), exp_hits);
    chk(miss_count == 16'(exp_miss), {rq, " miss_count"}, int'(miss_count), exp_miss);
  endtask

  // one load, with the hit/miss outcome the requirements predict
  task automatic load(input logic [4:0] a, input bit exp_hit, input string rq);
    @(negedge clk);
    chk(req_ready == 1'b1, {rq, " ready before load"}, int'(req_ready), 1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_hit) begin
      exp_hits++;
      chk(rsp_valid == 1'b1, {rq, " hit rsp_valid"}, int'(rsp_valid), 1);
      chk(rsp_hit == 1'b1, {rq, " rsp_hit"}, int'(rsp_hit), 1);
      chk(rsp_data == mem_byte(a), {rq, " hit data"}, int'(rsp_data), int'(mem_byte(a)));
      chk(mem_req_valid == 1'b0, {rq, " no fetch on hit"}, int'(mem_req_valid), 0);
    end else begin
      exp_miss++;
      chk(rsp_valid == 1'b0, {rq, " no early rsp"}, int'(rsp_valid), 0);
      for (int i = 0; i < LAT; i++) begin
        chk(mem_req_valid == 1'b1, "R3 fetch held", int'(mem_req_valid), 1);
        chk(mem_req_addr == a[4:1], "R2 block address", int'(mem_req_addr), int'(a[4:1]));
        chk(req_ready == 1'b0, "R3 busy during fetch", int'(req_ready), 0);
        @(negedge clk);
      end
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_block(a[4:1]);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      chk(rsp_valid == 1'b1, "R4 fill rsp_valid", int'(rsp_valid), 1);
      chk(rsp_hit == 1'b0, "R4 fill rsp_hit", int'(rsp_hit), 0);
      chk(rsp_data == mem_byte(a), "R4 fill data", int'(rsp_data), int'(mem_byte(a)));
      chk(mem_req_valid == 1'b0, "R3 fetch dropped", int'(mem_req_valid), 0);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, {rq, " rsp one cycle"}, int'(rsp_valid), 0);
    chk_counts({rq, " R9"});
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_hits = 0;
    exp_miss = 0;
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 no fetch after reset", int'(mem_req_valid), 0);
    chk_counts("R1");
  endtask

  task automatic t_fill_neighbour();
    load(5'd1, 1'b0, "R1 first load misses");
    load(5'd0, 1'b1, "R6 neighbour byte");
  endtask

  task automatic t_empty_way_first();
    load(5'd5, 1'b0, "R7 second tag in set0");
    load(5'd1, 1'b1, "R7 first tag kept");
    load(5'd5, 1'b1, "R7 second tag kept");
  endtask

  task automatic t_lru();
    load(5'd13, 1'b0, "R8 third tag evicts tag0");
    load(5'd5,  1'b1, "R8 tag1 survived");
    load(5'd0,  1'b0, "R8 tag0 was evicted");
    load(5'd4,  1'b1, "R8 tag1 still held");
    load(5'd12, 1'b0, "R8 tag3 was evicted");
    load(5'd1,  1'b0, "R8 tag0 evicted again");
    load(5'd13, 1'b1, "R8 tag3 kept");
  endtask

  task automatic t_sets();
    load(5'd2,  1'b0, "R10 set1 miss");
    load(5'd3,  1'b1, "R10 set1 neighbour");
    load(5'd12, 1'b1, "R10 set0 tag3 intact");
    load(5'd0,  1'b1, "R10 set0 tag0 intact");
  endtask

  task automatic t_busy();
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 5'd6;
    @(negedge clk);
    exp_miss++;
    req_addr = 5'd0;
    for (int i = 0; i < LAT; i++) begin
      chk(req_ready == 1'b0, "R11 ready low", int'(req_ready), 0);
      chk(rsp_valid == 1'b0, "R11 no rsp while busy", int'(rsp_valid), 0);
      @(negedge clk);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = mem_block(4'd3);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    req_valid     = 1'b0;
    chk(rsp_valid == 1'b1 && rsp_hit == 1'b0, "R11 only fill rsp", int'(rsp_hit), 0);
    chk(rsp_data == mem_byte(5'd6), "R11 fill data", int'(rsp_data), int'(mem_byte(5'd6)));
    chk_counts("R11 ignored load not counted");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 no late rsp", int'(rsp_valid), 0);
    chk_counts("R11 counts after");
    load(5'd7, 1'b1, "R6 fill after busy");
  endtask

  task automatic t_reset_clears();
    t_reset();
    load(5'd0, 1'b0, "R1 valid cleared by reset");
  endtask

  initial begin
    t_reset();
    t_fill_neighbour();
    t_empty_way_first();
    t_lru();
    t_sets();
    t_busy();
    t_reset_clears();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule